// File: doc/BRIEF.md
# CD Data Controller Register Bank

This block is the byte-wide register bank that a host uses to steer a CD data controller. The host selects a register with a 4-bit register pointer, then moves bytes through one data port. Reads and writes decode through two different maps. After most accesses the pointer steps on to the next register, so a run of registers can be read or written without reloading the pointer. The bank holds the transfer byte count, the transfer data address, the sector header, the pointer and write-address words, three control bytes, the sub-header output byte and the status word.

Some registers act as commands. Writing the trigger address starts a transfer. Writing interface control with its enable bit clear stops one. Writing the acknowledge address clears the end-of-transfer interrupt. Reading the last status byte clears the decode interrupt. Writing the reset address puts the bank back into its initial state. The block moves no data itself. It sends start and stop strobes, the busy flag, the count and the address to a separate transfer engine, and it takes a completion strobe back from that engine and a sector-ready strobe from the decoder.

Top module: `cdc_regfile`

## Requirements
- R1: Each read moves the pointer up by one, except a read while the pointer is 15, which leaves it at 15.
- R2: A write moves the pointer up by one at addresses 0-5 and 8-13. A write at 6, 7, 14 or 15 leaves the pointer unchanged.
- R3: Write map: 0 sub-header out, 1 interface control, 2/3 count low/high, 4/5 data address low/high, 6 trigger, 7 acknowledge, 8/9 write-address low/high, 10/11 control 0/1, 12/13 pointer-word low/high, 14 control 2, 15 reset. Read map: 0 command input, 1 interface status, 2/3 count low/high, 4-7 header bytes 0-3, 8/9 pointer-word low/high, 10/11 write-address low/high, 12-15 status bytes 0-3. `ctrl_word` is {control 2, control 1, control 0}.
- R4: After reset: interface status 0xFF, header bytes 0-3 read 00,00,00,01, status bytes 0-3 read 80,00,00,00, write address 0x1260 (4704), and every other register, the pointer, busy and done all 0.
- R5: A write of interface control with bit 1 clear sets the count to 0, clears busy, sets interface-status bit 3 (no transfer active) and pulses `xfer_stop` for one cycle.
- R6: A write at the trigger address starts a transfer only when interface-control bit 1 is set. A start clears interface-status bit 3, sets busy, clears `host_done` and pulses `xfer_start` for one cycle. Without the enable bit the write has no effect.
- R7: A write at the acknowledge address sets interface-status bit 6, the active-low end-of-transfer interrupt.
- R8: A `dec_ready` strobe clears interface-status bit 5, the active-low decode interrupt. A read of status byte 3 sets that bit again.
- R9: A write at address 15 restores every reset value of R4 except the pointer, which keeps its value.
- R10: `ptr_ld` loads `ptr_val` into the pointer and takes precedence over any advance. A read in the same cycle still returns the register at the old pointer.
- R11: An `eng_done` strobe clears busy, sets `host_done` and interface-status bit 3, and clears interface-status bit 6 when interface-control bit 6 is set.
- R12: Read data is registered. It shows up on `rdata` in the cycle after `rd_en`, holds the value from before that access's side effects, and stays until the next read. If `rd_en` and `wr_en` are both high, the write wins and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_ld | input | 1 | Load the register pointer |
| ptr_val | input | 4 | Value for a pointer load |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| cmd_in | input | 8 | Command-input byte, read at address 0 |
| eng_done | input | 1 | Transfer engine finished |
| dec_ready | input | 1 | Decoder has a sector ready |
| rdata | output | 8 | Registered read data |
| reg_ptr | output | 4 | Current register pointer |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_stop | output | 1 | One-cycle transfer stop strobe |
| xfer_busy | output | 1 | Transfer in progress |
| host_done | output | 1 | Transfer-finished bit of the host mode register |
| xfer_count | output | 16 | Transfer byte count |
| xfer_addr | output | 16 | Transfer data address |
| ctrl_word | output | 24 | Control bytes 2,1,0 |
| sub_hdr_out | output | 8 | Sub-header output byte |

## Verification
The assertions check the pointer movement rules after reads, writes and loads on every cycle. They also check the immediate effects of start, stop and engine completion on busy, the strobes and the count. The scenarios are what show the two address maps lining up, the reset values, and the interface-status bits that the acknowledge, the decode strobe and the status-byte-3 read change, because those are only visible by reading back through the data port. The soft reset keeping the pointer, and a load overriding an advance, are also shown by directed sequences.

// File: rtl/cdcr_pkg.sv
package cdcr_pkg;
   typedef enum logic [3:0] {
      W_SBOUT = 4'd0, W_IFCTRL, W_CNT_L, W_CNT_H, W_ADR_L, W_ADR_H, W_TRIG, W_ACK,
      W_WA_L, W_WA_H, W_CTL0, W_CTL1, W_PT_L, W_PT_H, W_CTL2, W_RESET
   } wreg_e;

   typedef enum logic [3:0] {
      R_CMD = 4'd0, R_IFST, R_CNT_L, R_CNT_H, R_HD0, R_HD1, R_HD2, R_HD3,
      R_PT_L, R_PT_H, R_WA_L, R_WA_H, R_ST0, R_ST1, R_ST2, R_ST3
   } rreg_e;

   // interface status bits (active low flags)
   localparam int IFS_IDLE = 3;
   localparam int IFS_DEC  = 5;
   localparam int IFS_DTE  = 6;
   // interface control bits
   localparam int IFC_XEN   = 1;
   localparam int IFC_DTEIE = 6;

   // writes at these addresses leave the pointer in place
   function automatic logic wr_steps(input logic [3:0] a);
      return !(a == W_TRIG || a == W_ACK || a == W_CTL2 || a == W_RESET);
   endfunction
endpackage

// File: rtl/cdcr_ptr.sv
module cdcr_ptr #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          rd,
   input  logic          wr,
   output logic [AW-1:0] ptr
);
   import cdcr_pkg::*;
   localparam logic [AW-1:0] LAST = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (ld)
         ptr <= ld_val;
      else if (wr) begin
         if (wr_steps(4'(ptr)))
            ptr <= ptr + 1'b1;
      end else if (rd && ptr != LAST)
         ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/cdcr_rdmux.sv
module cdcr_rdmux #(
   parameter int DW       = 8,
   parameter int AW       = 4,
   parameter bit READ_REG = 1'b1,
   localparam int NREG    = 1 << AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd,
   input  logic [AW-1:0]      ptr,
   input  logic [NREG*DW-1:0] src,
   output logic [DW-1:0]      rdata
);
   logic [DW-1:0] sel;
   assign sel = src[ptr*DW +: DW];

   generate
      if (READ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  rdata <= '0;
            else if (rd) rdata <= sel;
         end
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, rd};
         assign rdata = sel;
      end
   endgenerate
endmodule

// File: rtl/cdc_regfile.sv
module cdc_regfile #(
   parameter int          DW       = 8,
   parameter int          AW       = 4,
   parameter int          CW       = 16,
   parameter int          HW       = 32,
   parameter logic [7:0]  IFST_RST = 8'hFF,
   parameter logic [31:0] HEAD_RST = 32'h0100_0000,
   parameter logic [31:0] STAT_RST = 32'h0000_0080,
   parameter int          WA_RST   = 4704,
   parameter bit          READ_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ptr_ld,
   input  logic [AW-1:0]  ptr_val,
   input  logic           rd_en,
   input  logic           wr_en,
   input  logic [DW-1:0]  wdata,
   input  logic [DW-1:0]  cmd_in,
   input  logic           eng_done,
   input  logic           dec_ready,
   output logic [DW-1:0]  rdata,
   output logic [AW-1:0]  reg_ptr,
   output logic           xfer_start,
   output logic           xfer_stop,
   output logic           xfer_busy,
   output logic           host_done,
   output logic [CW-1:0]  xfer_count,
   output logic [CW-1:0]  xfer_addr,
   output logic [3*DW-1:0] ctrl_word,
   output logic [DW-1:0]  sub_hdr_out
);
   import cdcr_pkg::*;
   localparam int NREG = 1 << AW;

   generate
      if (DW != 8)      begin : g_bad_dw $error("DW must be 8"); end
      if (AW != 4)      begin : g_bad_aw $error("AW must be 4"); end
      if (CW != 2 * DW) begin : g_bad_cw $error("CW must be 2*DW"); end
      if (HW != 4 * DW) begin : g_bad_hw $error("HW must be 4*DW"); end
   endgenerate

   typedef struct packed {
      logic [DW-1:0] sbout, ifctrl, ifstat, ctl0, ctl1, ctl2;
      logic [CW-1:0] cnt, adr, wa, pt;
      logic [HW-1:0] head, stat;
      logic          busy, done, start, stop;
   } regs_t;

   localparam regs_t INIT = '{
      sbout: '0, ifctrl: '0, ifstat: DW'(IFST_RST), ctl0: '0, ctl1: '0, ctl2: '0,
      cnt: '0, adr: '0, wa: CW'(WA_RST), pt: '0,
      head: HW'(HEAD_RST), stat: HW'(STAT_RST),
      busy: 1'b0, done: 1'b0, start: 1'b0, stop: 1'b0};

   regs_t         r_q, r_d;
   logic          rd_live;
   logic [NREG*DW-1:0] rsrc;

   assign rd_live = rd_en & ~wr_en;

   cdcr_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .ld_val(ptr_val),
      .rd(rd_live), .wr(wr_en), .ptr(reg_ptr));

   // read map, address 15 down to 0
   assign rsrc = {r_q.stat[4*DW-1:3*DW], r_q.stat[3*DW-1:2*DW], r_q.stat[2*DW-1:DW], r_q.stat[DW-1:0],
                  r_q.wa[CW-1:DW], r_q.wa[DW-1:0], r_q.pt[CW-1:DW], r_q.pt[DW-1:0],
                  r_q.head[4*DW-1:3*DW], r_q.head[3*DW-1:2*DW], r_q.head[2*DW-1:DW], r_q.head[DW-1:0],
                  r_q.cnt[CW-1:DW], r_q.cnt[DW-1:0], r_q.ifstat, cmd_in};

   cdcr_rdmux #(.DW(DW), .AW(AW), .READ_REG(READ_REG)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .rd(rd_live), .ptr(reg_ptr), .src(rsrc), .rdata(rdata));

   always_comb begin
      r_d       = r_q;
      r_d.start = 1'b0;
      r_d.stop  = 1'b0;
      if (eng_done) begin
         r_d.busy             = 1'b0;
         r_d.done             = 1'b1;
         r_d.ifstat[IFS_IDLE] = 1'b1;
         if (r_q.ifctrl[IFC_DTEIE]) r_d.ifstat[IFS_DTE] = 1'b0;
      end
      if (dec_ready) r_d.ifstat[IFS_DEC] = 1'b0;
      if (rd_live && reg_ptr == R_ST3) r_d.ifstat[IFS_DEC] = 1'b1;
      if (wr_en) begin
         case (reg_ptr)
            W_SBOUT:  r_d.sbout = wdata;
            W_IFCTRL: begin
               r_d.ifctrl = wdata;
               if (!wdata[IFC_XEN]) begin
                  r_d.cnt              = '0;
                  r_d.busy             = 1'b0;
                  r_d.ifstat[IFS_IDLE] = 1'b1;
                  r_d.stop             = 1'b1;
               end
            end
            W_CNT_L:  r_d.cnt[DW-1:0]  = wdata;
            W_CNT_H:  r_d.cnt[CW-1:DW] = wdata;
            W_ADR_L:  r_d.adr[DW-1:0]  = wdata;
            W_ADR_H:  r_d.adr[CW-1:DW] = wdata;
            W_TRIG: begin
               if (r_q.ifctrl[IFC_XEN]) begin
                  r_d.ifstat[IFS_IDLE] = 1'b0;
                  r_d.busy             = 1'b1;
                  r_d.done             = 1'b0;
                  r_d.start            = 1'b1;
               end
            end
            W_ACK:    r_d.ifstat[IFS_DTE] = 1'b1;
            W_WA_L:   r_d.wa[DW-1:0]  = wdata;
            W_WA_H:   r_d.wa[CW-1:DW] = wdata;
            W_CTL0:   r_d.ctl0 = wdata;
            W_CTL1:   r_d.ctl1 = wdata;
            W_PT_L:   r_d.pt[DW-1:0]  = wdata;
            W_PT_H:   r_d.pt[CW-1:DW] = wdata;
            W_CTL2:   r_d.ctl2 = wdata;
            default:  r_d = INIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= INIT;
      else        r_q <= r_d;
   end

   assign xfer_start  = r_q.start;
   assign xfer_stop   = r_q.stop;
   assign xfer_busy   = r_q.busy;
   assign host_done   = r_q.done;
   assign xfer_count  = r_q.cnt;
   assign xfer_addr   = r_q.adr;
   assign ctrl_word   = {r_q.ctl2, r_q.ctl1, r_q.ctl0};
   assign sub_hdr_out = r_q.sbout;
endmodule

// File: rtl/cdc_regfile_chk.sv
module cdc_regfile_chk #(
   parameter int AW = 4,
   parameter int DW = 8,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_en,
   input logic          wr_en,
   input logic          ptr_ld,
   input logic [AW-1:0] ptr_val,
   input logic [DW-1:0] wdata,
   input logic          eng_done,
   input logic [AW-1:0] reg_ptr,
   input logic [DW-1:0] ifctrl,
   input logic          xfer_busy,
   input logic          xfer_start,
   input logic          xfer_stop,
   input logic          host_done,
   input logic [CW-1:0] xfer_count
);
   localparam logic [AW-1:0] LAST = '1;

   p_rd_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en && !ptr_ld && reg_ptr != LAST |=> reg_ptr == $past(reg_ptr) + 1'b1);

   p_rd_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en && !ptr_ld && reg_ptr == LAST |=> reg_ptr == LAST);

   p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !ptr_ld && (reg_ptr == 6 || reg_ptr == 7 || reg_ptr == 14 || reg_ptr == 15)
      |=> $stable(reg_ptr));

   p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && reg_ptr == 1 && !wdata[1] |=> xfer_count == '0 && !xfer_busy && xfer_stop);

   p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && reg_ptr == 6 && ifctrl[1] |=> xfer_busy && xfer_start && !host_done);

   p_nostart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && reg_ptr == 6 && !ifctrl[1] |=> !xfer_start);

   p_ptr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_ld |=> reg_ptr == $past(ptr_val));

   p_eng_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done && !wr_en |=> !xfer_busy && host_done);
endmodule

bind cdc_regfile cdc_regfile_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .ptr_ld(ptr_ld),
   .ptr_val(ptr_val), .wdata(wdata), .eng_done(eng_done), .reg_ptr(reg_ptr),
   .ifctrl(r_q.ifctrl), .xfer_busy(xfer_busy), .xfer_start(xfer_start),
   .xfer_stop(xfer_stop), .host_done(host_done), .xfer_count(xfer_count));

// File: tb/cdc_regfile_bench.sv
module cdc_regfile_bench;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ptr_ld = 1'b0, rd_en = 1'b0, wr_en = 1'b0, eng_done = 1'b0, dec_ready = 1'b0;
   logic [3:0]  ptr_val = '0;
   logic [7:0]  wdata = '0, cmd_in = 8'h3C;
   logic [7:0]  rdata, sub_hdr_out;
   logic [3:0]  reg_ptr;
   logic        xfer_start, xfer_stop, xfer_busy, host_done;
   logic [15:0] xfer_count, xfer_addr;
   logic [23:0] ctrl_word;

   int errors = 0, checks = 0;
   bit finished = 1'b0;
   logic [7:0] exp_q[$];
   string      req_q[$];
   logic       rd_seen = 1'b0;

   always #4 clk = ~clk;

   cdc_regfile u_cdc_regfile (
      .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_val(ptr_val), .rd_en(rd_en),
      .wr_en(wr_en), .wdata(wdata), .cmd_in(cmd_in), .eng_done(eng_done),
      .dec_ready(dec_ready), .rdata(rdata), .reg_ptr(reg_ptr), .xfer_start(xfer_start),
      .xfer_stop(xfer_stop), .xfer_busy(xfer_busy), .host_done(host_done),
      .xfer_count(xfer_count), .xfer_addr(xfer_addr), .ctrl_word(ctrl_word),
      .sub_hdr_out(sub_hdr_out));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all driver tasks start and end at a falling edge
   task automatic setp(input logic [3:0] p);
      ptr_ld = 1'b1; ptr_val = p;
      @(negedge clk);
      ptr_ld = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] exp, input string req);
      rd_en = 1'b1;
      exp_q.push_back(exp);
      req_q.push_back(req);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse_done();
      eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
   endtask

   task automatic pulse_dec();
      dec_ready = 1'b1; @(negedge clk); dec_ready = 1'b0;
   endtask

   // monitor: registered read data is valid at the falling edge after the read edge
   always @(posedge clk) rd_seen <= rd_en && !wr_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) chk("R12 unexpected read", 32'h1, 32'h0);
         else chk(req_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 reset state at the ports
      chk("R4 pointer", 32'(reg_ptr), 0);
      chk("R4 busy", 32'(xfer_busy), 0);
      chk("R4 done", 32'(host_done), 0);
      chk("R4 count", 32'(xfer_count), 0);
      chk("R4 ctrl", 32'(ctrl_word), 0);

      // R3/R4 read map from the command byte up to status byte 3
      rd(8'h3C, "R3 command input");
      chk("R1 step", 32'(reg_ptr), 1);
      rd(8'hFF, "R4 ifstat");
      rd(8'h00, "R4 count low");
      rd(8'h00, "R4 count high");
      rd(8'h00, "R4 head0"); rd(8'h00, "R4 head1"); rd(8'h00, "R4 head2");
      rd(8'h01, "R4 head3");
      rd(8'h00, "R4 pt low"); rd(8'h00, "R4 pt high");
      rd(8'h60, "R4 wa low"); rd(8'h12, "R4 wa high");
      rd(8'h80, "R4 stat0"); rd(8'h00, "R4 stat1"); rd(8'h00, "R4 stat2");
      chk("R1 reached 15", 32'(reg_ptr), 15);
      rd(8'h00, "R4 stat3");
      chk("R1 hold at 15", 32'(reg_ptr), 15);
      rd(8'h00, "R1 reread stat3");
      chk("R1 still 15", 32'(reg_ptr), 15);

      // R2/R3 write run 0..5
      setp(0);
      wr(8'hA5); wr(8'h42); wr(8'h34); wr(8'h12); wr(8'h78); wr(8'h56);
      chk("R2 advanced to 6", 32'(reg_ptr), 6);
      chk("R3 sub-header", 32'(sub_hdr_out), 32'hA5);
      chk("R3 count", 32'(xfer_count), 32'h1234);
      chk("R3 address", 32'(xfer_addr), 32'h5678);

      // R6 start with enable set
      wr(8'h00);
      chk("R2 trigger holds", 32'(reg_ptr), 6);
      chk("R6 start pulse", 32'(xfer_start), 1);
      chk("R6 busy", 32'(xfer_busy), 1);
      @(negedge clk);
      chk("R6 pulse one cycle", 32'(xfer_start), 0);
      setp(1);
      rd(8'hF7, "R6 ifstat idle bit clear");

      // R11 engine completion with interrupt enable
      pulse_done();
      chk("R11 busy cleared", 32'(xfer_busy), 0);
      chk("R11 done set", 32'(host_done), 1);
      setp(1);
      rd(8'hBF, "R11 ifstat");

      // R7 acknowledge
      setp(7);
      wr(8'h00);
      chk("R2 ack holds", 32'(reg_ptr), 7);
      setp(1);
      rd(8'hFF, "R7 ifstat after ack");

      // R8 decode flag
      pulse_dec();
      setp(1);
      rd(8'hDF, "R8 decode flag low");
      setp(15);
      rd(8'h00, "R8 stat3 read");
      setp(1);
      rd(8'hFF, "R8 decode flag released");

      // R3 write run 8..14
      setp(8);
      wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44); wr(8'h55); wr(8'h66);
      chk("R2 advanced to 14", 32'(reg_ptr), 14);
      wr(8'h77);
      chk("R2 ctrl2 holds", 32'(reg_ptr), 14);
      chk("R3 ctrl word", 32'(ctrl_word), 32'h774433);
      setp(8);
      rd(8'h55, "R3 pt low"); rd(8'h66, "R3 pt high");
      rd(8'h11, "R3 wa low"); rd(8'h22, "R3 wa high");

      // R10 load beats advance, read uses old pointer
      setp(8);
      ptr_ld = 1'b1; ptr_val = 4'd3; rd(8'h55, "R10 read at old pointer");
      ptr_ld = 1'b0;
      chk("R10 load wins", 32'(reg_ptr), 3);

      // R12 write wins over read in the same cycle
      setp(2);
      rd_en = 1'b1; wr(8'h9A); rd_en = 1'b0;
      chk("R12 write wins pointer", 32'(reg_ptr), 3);
      chk("R12 write wins data", 32'(xfer_count), 32'h129A);
      chk("R12 rdata unchanged", 32'(rdata), 32'h55);

      // R5 stop
      setp(6);
      wr(8'h00);
      chk("R6 restart busy", 32'(xfer_busy), 1);
      chk("R6 restart clears done", 32'(host_done), 0);
      setp(1);
      wr(8'h40);
      chk("R5 stop pulse", 32'(xfer_stop), 1);
      chk("R5 count zero", 32'(xfer_count), 0);
      chk("R5 busy cleared", 32'(xfer_busy), 0);
      setp(1);
      rd(8'hFF, "R5 ifstat idle set");

      // R6 trigger without enable has no effect
      setp(6);
      wr(8'h00);
      chk("R6 no start pulse", 32'(xfer_start), 0);
      chk("R6 no busy", 32'(xfer_busy), 0);
      setp(1);
      rd(8'hFF, "R6 ifstat unchanged");

      // R9 soft reset keeps pointer
      setp(0); wr(8'h5A);
      setp(15);
      wr(8'h00);
      chk("R9 pointer kept", 32'(reg_ptr), 15);
      chk("R9 ctrl cleared", 32'(ctrl_word), 0);
      chk("R9 sub-header cleared", 32'(sub_hdr_out), 0);
      setp(10);
      rd(8'h60, "R9 wa low restored");
      rd(8'h12, "R9 wa high restored");
      setp(8);
      rd(8'h00, "R9 pt cleared");

      @(negedge clk);
      chk("R12 queue drained", 32'(exp_q.size()), 0);
      finish_run();
   end
endmodule